// File: doc/BRIEF.md
# Weighted Dispatch Group Slot Tracker

This block follows how many slots of the current instruction dispatch group are taken as an instruction scheduler hands it instructions one at a time, in program order. The scheduler supplies each instruction as a class code, a record-form flag, a branch flag and a flag saying the instruction is a load that depends in order on a store already in the group. For each emitted instruction the block returns the number of slots it takes and whether it has to open a group. It also returns a hint that the scheduler should pick a different candidate, a load-after-store hazard, and the number of no-ops to insert ahead of it.

The scheduler can also report that it emitted a no-op, which either closes the group or takes one slot. A flush input empties the group in a single cycle. All per-instruction results are registered and appear, marked by a valid strobe, one cycle after the emit strobe. The current group fill is visible at all times.

Top module: `dgst_tracker`

## Requirements
- R1: Class codes 4 to 7 take 2 slots, codes 8 to 12 take 4 slots, and every other code (0 to 3, 13 to 15) takes 1 slot.
- R2: When the record-form flag is set, an instruction whose class would take 1 slot takes 2 instead. Classes of 2 or 4 slots keep their weight.
- R3: An instruction must open a group when its weight is above 1, or when its class is 1 (condition-register logical), 2 (move from condition register) or 3 (move to special register).
- R4: On emit, the group is emptied before the instruction is added if the fill is exactly 5, or if the instruction is a branch and the group already holds a branch. The instruction's weight is then added.
- R5: A must-open instruction emitted while the fill is nonzero restarts the group, so the fill becomes its own weight.
- R6: The prefer-another output is 1 exactly when the emitted instruction must open a group and the fill it met was nonzero.
- R7: The hazard output repeats the load-after-store flag. When that flag is set and the fill met is below 6, the no-op count is 1 in terminating-no-op mode and 5 minus the fill otherwise. In every other case it is 0.
- R8: An emitted no-op empties the group in terminating-no-op mode or when the fill is 6. Otherwise it adds one slot.
- R9: Flush empties the fill and the branch count by the next cycle. It overrides an emit or a no-op in the same cycle, and such an emit produces no valid result.
- R10: When an emit and a no-op arrive in the same cycle, the no-op is applied first. The instruction's results and the group update are then computed against the fill the no-op left.
- R11: Per-instruction outputs are registered and qualified by a valid strobe one cycle after the emit. The fill saturates at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the group this cycle |
| emit_i | input | 1 | An instruction is emitted this cycle |
| cls_i | input | 4 | Class code of the emitted instruction |
| rec_i | input | 1 | Record-form flag |
| br_i | input | 1 | Instruction is a branch |
| las_i | input | 1 | Load ordered after a store in this group |
| nop_i | input | 1 | A no-op is emitted this cycle |
| term_nop_i | input | 1 | Group-terminating no-op mode |
| vld_o | output | 1 | Per-instruction outputs valid |
| wt_o | output | 3 | Slot weight of the instruction |
| first_o | output | 1 | Instruction must open a group |
| prefer_o | output | 1 | Scheduler should prefer another candidate |
| hazard_o | output | 1 | Load-after-store no-op hazard |
| nopcnt_o | output | 3 | No-ops to insert before the instruction |
| fill_o | output | 4 | Current group fill in slots |

## Verification
Two pairs of functions can land in the same cycle. A no-op report and an emit are raised together on a group of fill 4. The no-op takes the fill to 5, so the instruction must clear the group and end at fill 1, not 5. A load-after-store emit raised with a no-op must also report its no-op count against the fill the no-op left. Flush is raised together with an emit, and with a branch left in the group. The bench then expects no valid result and a fill of 0, and the next branch must not close the group.

// File: rtl/dgst_pkg.sv
package dgst_pkg;
    // instruction class codes seen on cls_i
    localparam logic [3:0] IC_PLAIN  = 4'd0;
    localparam logic [3:0] IC_CRLOG  = 4'd1;
    localparam logic [3:0] IC_MFCR   = 4'd2;
    localparam logic [3:0] IC_MTSPR  = 4'd3;
    localparam logic [3:0] IC_DIV    = 4'd4;
    localparam logic [3:0] IC_LDUPD  = 4'd5;
    localparam logic [3:0] IC_LDALG  = 4'd6;
    localparam logic [3:0] IC_STUPD  = 4'd7;
    localparam logic [3:0] IC_LDUPDX = 4'd8;
    localparam logic [3:0] IC_LDRSV  = 4'd9;
    localparam logic [3:0] IC_STCOND = 4'd10;
    localparam logic [3:0] IC_STUPDX = 4'd11;
    localparam logic [3:0] IC_MTCR   = 4'd12;
endpackage

// File: rtl/dgst_weigh.sv
module dgst_weigh
    import dgst_pkg::*;
#(
    parameter int CLS_W = 4,
    parameter int WT_W  = 3
) (
    input  logic [CLS_W-1:0] cls_i,
    input  logic             rec_i,
    output logic [WT_W-1:0]  wt_o,
    output logic             first_o
);
    localparam logic [WT_W-1:0] W1 = WT_W'(1);
    localparam logic [WT_W-1:0] W2 = WT_W'(2);
    localparam logic [WT_W-1:0] W4 = WT_W'(4);

    logic [WT_W-1:0] base;
    logic            forced_first;

    always_comb begin
        base = W1;
        forced_first = 1'b0;
        case (4'(cls_i))
            IC_DIV, IC_LDUPD, IC_LDALG, IC_STUPD:               base = W2;
            IC_LDUPDX, IC_LDRSV, IC_STCOND, IC_STUPDX, IC_MTCR:  base = W4;
            IC_CRLOG, IC_MFCR, IC_MTSPR:                          forced_first = 1'b1;
            default:                                              base = W1;
        endcase
        wt_o    = (base == W1 && rec_i) ? W2 : base;
        first_o = forced_first || (wt_o != W1);
    end
endmodule

// File: rtl/dgst_group.sv
module dgst_group #(
    parameter int FILL_W    = 4,
    parameter int WT_W      = 3,
    parameter int GRP_SLOTS = 5,
    parameter int NOP_CLR   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              emit_i,
    input  logic              nop_i,
    input  logic              term_i,
    input  logic              br_i,
    input  logic              first_i,
    input  logic [WT_W-1:0]   wt_i,
    output logic [FILL_W-1:0] fill_q_o,
    output logic [FILL_W-1:0] fill_pre_o
);
    localparam int               BR_W     = 2;
    localparam logic [FILL_W-1:0] EMIT_CLR = FILL_W'(GRP_SLOTS);
    localparam logic [FILL_W-1:0] NOPC     = FILL_W'(NOP_CLR);
    localparam logic [FILL_W-1:0] FILL_MAX = {FILL_W{1'b1}};

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic [BR_W-1:0]   brs;
    } grp_t;

    grp_t st_q, st_d, mid;

    function automatic logic [FILL_W-1:0] sat_add(input logic [FILL_W-1:0] a,
                                                  input logic [WT_W-1:0]   b);
        logic [FILL_W:0] s;
        s = {1'b0, a} + {{(FILL_W+1-WT_W){1'b0}}, b};
        return s[FILL_W] ? FILL_MAX : s[FILL_W-1:0];
    endfunction

    always_comb begin
        // no-op report is applied ahead of a same-cycle emit
        mid = st_q;
        if (nop_i) begin
            if (term_i || mid.fill == NOPC) mid = '0;
            else                            mid.fill = sat_add(mid.fill, WT_W'(1));
        end
        st_d = mid;
        if (emit_i) begin
            if (mid.fill == EMIT_CLR || (br_i && mid.brs != '0)) st_d = '0;
            if (first_i && st_d.fill != '0)                      st_d = '0;
            st_d.fill = sat_add(st_d.fill, wt_i);
            if (br_i) st_d.brs = st_d.brs + BR_W'(1);
        end
        if (flush_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fill_q_o   = st_q.fill;
    assign fill_pre_o = mid.fill;

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.fill == '0 && st_q.brs == '0)); // R9
    AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.brs <= BR_W'(1)); // R4
    AST_TERM_NOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (nop_i && term_i && !emit_i && !flush_i) |=> st_q.fill == '0); // R8
    AST_NOP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (nop_i && !term_i && !emit_i && !flush_i && st_q.fill != NOPC && st_q.fill != FILL_MAX)
        |=> st_q.fill == $past(st_q.fill) + 1'b1); // R8
endmodule

// File: rtl/dgst_nopq.sv
module dgst_nopq #(
    parameter int FILL_W    = 4,
    parameter int CNT_W     = 3,
    parameter int GRP_SLOTS = 5,
    parameter int NOP_CLR   = 6
) (
    input  logic [FILL_W-1:0] fill_i,
    input  logic              las_i,
    input  logic              term_i,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [FILL_W-1:0] EMIT_CLR = FILL_W'(GRP_SLOTS);
    localparam logic [FILL_W-1:0] NOPC     = FILL_W'(NOP_CLR);

    always_comb begin
        cnt_o = '0;
        if (las_i && fill_i < NOPC) begin
            if (term_i)                 cnt_o = CNT_W'(1);
            else if (fill_i <= EMIT_CLR) cnt_o = CNT_W'(EMIT_CLR - fill_i);
            else                         cnt_o = '0;
        end
    end
endmodule

// File: rtl/dgst_tracker.sv
module dgst_tracker #(
    parameter int CLS_W     = 4,
    parameter int FILL_W    = 4,
    parameter int WT_W      = 3,
    parameter int CNT_W     = 3,
    parameter int GRP_SLOTS = 5,
    parameter int NOP_CLR   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              emit_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic              rec_i,
    input  logic              br_i,
    input  logic              las_i,
    input  logic              nop_i,
    input  logic              term_nop_i,
    output logic              vld_o,
    output logic [WT_W-1:0]   wt_o,
    output logic              first_o,
    output logic              prefer_o,
    output logic              hazard_o,
    output logic [CNT_W-1:0]  nopcnt_o,
    output logic [FILL_W-1:0] fill_o
);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(GRP_SLOTS);

    typedef struct packed {
        logic             vld;
        logic [WT_W-1:0]  wt;
        logic             first;
        logic             prefer;
        logic             hazard;
        logic [CNT_W-1:0] nopcnt;
    } res_t;

    logic [WT_W-1:0]   cand_wt;
    logic              cand_first;
    logic [FILL_W-1:0] fill_pre;
    logic [CNT_W-1:0]  cand_cnt;
    res_t              res_d, res_q;

    dgst_weigh #(.CLS_W(CLS_W), .WT_W(WT_W)) u_weigh (
        .cls_i   (cls_i),
        .rec_i   (rec_i),
        .wt_o    (cand_wt),
        .first_o (cand_first)
    );

    dgst_group #(.FILL_W(FILL_W), .WT_W(WT_W), .GRP_SLOTS(GRP_SLOTS), .NOP_CLR(NOP_CLR)) u_group (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .emit_i     (emit_i),
        .nop_i      (nop_i),
        .term_i     (term_nop_i),
        .br_i       (br_i),
        .first_i    (cand_first),
        .wt_i       (cand_wt),
        .fill_q_o   (fill_o),
        .fill_pre_o (fill_pre)
    );

    dgst_nopq #(.FILL_W(FILL_W), .CNT_W(CNT_W), .GRP_SLOTS(GRP_SLOTS), .NOP_CLR(NOP_CLR)) u_nopq (
        .fill_i (fill_pre),
        .las_i  (las_i),
        .term_i (term_nop_i),
        .cnt_o  (cand_cnt)
    );

    always_comb begin
        res_d.vld    = emit_i && !flush_i;
        res_d.wt     = cand_wt;
        res_d.first  = cand_first;
        res_d.prefer = cand_first && (fill_pre != '0);
        res_d.hazard = las_i;
        res_d.nopcnt = cand_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign vld_o    = res_q.vld;
    assign wt_o     = res_q.wt;
    assign first_o  = res_q.first;
    assign prefer_o = res_q.prefer;
    assign hazard_o = res_q.hazard;
    assign nopcnt_o = res_q.nopcnt;

    AST_WT_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $countones(wt_o) == 1); // R1
    AST_MULTI_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && wt_o > WT_W'(1)) |-> first_o); // R3
    AST_PREFER_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        prefer_o |-> first_o); // R6
    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_i && !flush_i) |=> vld_o); // R11
    AST_FLUSH_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !vld_o); // R9
    AST_NOPCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        nopcnt_o <= CNT_LIM); // R7
    AST_NOPCNT_NEEDS_HAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (nopcnt_o != '0) |-> hazard_o); // R7
endmodule

// File: tb/dgst_tracker_test.sv
module dgst_tracker_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 0, emit_i = 0, rec_i = 0, br_i = 0, las_i = 0, nop_i = 0, term_nop_i = 0;
    logic [3:0] cls_i = '0;
    logic       vld_o, first_o, prefer_o, hazard_o;
    logic [2:0] wt_o, nopcnt_o;
    logic [3:0] fill_o;

    always #4 clk = ~clk;

    dgst_tracker uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .emit_i(emit_i), .cls_i(cls_i),
        .rec_i(rec_i), .br_i(br_i), .las_i(las_i), .nop_i(nop_i), .term_nop_i(term_nop_i),
        .vld_o(vld_o), .wt_o(wt_o), .first_o(first_o), .prefer_o(prefer_o),
        .hazard_o(hazard_o), .nopcnt_o(nopcnt_o), .fill_o(fill_o)
    );

    typedef struct {
        int    wt;
        bit    first;
        bit    prefer;
        bit    haz;
        int    nc;
        int    fill;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    int   mfill = 0;
    int   mbr = 0;

    function automatic int wt_of(int c, bit r);
        int b;
        if (c >= 4 && c <= 7)       b = 2;
        else if (c >= 8 && c <= 12) b = 4;
        else                        b = 1;
        if (b == 1 && r) b = 2;
        return b;
    endfunction

    function automatic bit first_of(int c, bit r);
        return (wt_of(c, r) > 1) || c == 1 || c == 2 || c == 3;
    endfunction

    task automatic step(input bit e, input int c, input bit r, input bit b, input bit l,
                        input bit n, input bit t, input bit f, input string tag);
        exp_t x;
        int   w;
        bit   fs;
        @(negedge clk);
        emit_i = e; cls_i = 4'(c); rec_i = r; br_i = b; las_i = l;
        nop_i = n; term_nop_i = t; flush_i = f;
        if (f) begin
            mfill = 0; mbr = 0;
        end else begin
            if (n) begin
                if (t || mfill == 6) begin mfill = 0; mbr = 0; end
                else mfill = (mfill + 1 > 15) ? 15 : mfill + 1;
            end
            if (e) begin
                w  = wt_of(c, r);
                fs = first_of(c, r);
                x.wt = w; x.first = fs; x.prefer = fs && mfill != 0; x.haz = l;
                x.nc = (l && mfill < 6) ? (t ? 1 : 5 - mfill) : 0;
                if (mfill == 5 || (b && mbr != 0)) begin mfill = 0; mbr = 0; end
                if (fs && mfill != 0) begin mfill = 0; mbr = 0; end
                mfill = (mfill + w > 15) ? 15 : mfill + w;
                if (b) mbr = mbr + 1;
                x.fill = mfill; x.tag = tag;
                q.push_back(x);
            end
        end
        @(posedge clk);
        #1;
        emit_i = 0; nop_i = 0; flush_i = 0; br_i = 0; las_i = 0; rec_i = 0;
    endtask

    task automatic chk_fill(input int expf, input string tag);
        @(negedge clk);
        total++;
        if (fill_o != 4'(expf) || vld_o !== 1'b0) begin
            bad++;
            $display("FAIL %s fill=%0d vld=%0b expected fill=%0d vld=0", tag, fill_o, vld_o, expf);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && vld_o) begin
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected valid output, expected none");
            end else begin
                exp_t x;
                x = q.pop_front();
                if (int'(wt_o) != x.wt || first_o != x.first || prefer_o != x.prefer ||
                    hazard_o != x.haz || int'(nopcnt_o) != x.nc || int'(fill_o) != x.fill) begin
                    bad++;
                    $display("FAIL %s got wt=%0d first=%0b pref=%0b haz=%0b nc=%0d fill=%0d exp wt=%0d first=%0b pref=%0b haz=%0b nc=%0d fill=%0d",
                             x.tag, wt_o, first_o, prefer_o, hazard_o, nopcnt_o, fill_o,
                             x.wt, x.first, x.prefer, x.haz, x.nc, x.fill);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (fill_o != 0 || vld_o !== 1'b0) begin
            bad++;
            $display("FAIL reset fill=%0d vld=%0b expected 0 0", fill_o, vld_o);
        end
        rst_n = 1'b1;

        // R4: fill to 5, next emit clears then adds
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        // R1: every class code
        for (int c = 0; c < 16; c++) step(1, c, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        // R2: record form
        step(1, 0, 1, 0, 0, 0, 0, 0, "R2");
        step(1, 4, 1, 0, 0, 0, 0, 0, "R2");
        step(1, 12, 1, 0, 0, 0, 0, 0, "R2");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R2");
        step(1, 15, 1, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        // R3 R5 R6: must-open classes restart a partial group
        step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 3, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 2, 0, 0, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 4, 0, 0, 0, 0, 0, 0, "R5");
        // R4: second branch closes the group
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 1, 0, 0, 0, 0, "R4");
        // R7: no-op counts in both modes
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 1, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 1, 0, 1, 0, "R7");
        step(1, 0, 0, 0, 1, 0, 0, 0, "R7");
        // R8: no-op emission
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R8");
        chk_fill(6, "R8");
        step(1, 0, 0, 0, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 1, 0, "R8");
        chk_fill(0, "R8");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R8");
        chk_fill(0, "R8");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R8");
        chk_fill(2, "R8");
        // R10: emit and no-op together
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, 0, 1, 0, 0, "R10");
        step(1, 0, 0, 0, 1, 1, 0, 0, "R10");
        // R9: flush beats emit, branch count cleared
        step(1, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 1, "R9");
        chk_fill(0, "R9");
        step(1, 0, 0, 1, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 1, 0, 0, 0, 0, "R9");
        // R11: saturation of the fill
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 1, 0, 0, "R11");
        for (int i = 0; i < 11; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R11");

        repeat (4) @(negedge clk);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R11 %0d results missing, expected 0", q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule